// File: doc/BRIEF.md
# Read-Only Parallel Input Port Decoder

This block connects a set of digital input lines to an 8-bit I/O-mapped host bus. The lines are organised as groups of three byte-wide ports (A, B, C). Each group occupies four consecutive bus offsets, and the fourth offset of every group is a reserved slot. Software written for a three-port peripheral that has been configured as all inputs therefore finds its data where it expects it.

A bank of switches sets the base address. Each switch stands for one bus address line, and a closed switch adds that line's binary weight. The block compares the upper address bits with the switch value. When a read strobe hits the window, the selected port's byte is registered onto the data output and the output enable is raised for one cycle. Write strobes are accepted on the bus and have no effect. Each input line passes through a two-flop synchronizer before it reaches the byte multiplexer. The number of groups is a parameter (2, 4 or 8), which gives windows of 8, 16 or 32 bytes.

Top module: `ioin_decoder`

## Requirements
- R1: A cycle with `bus_rd`=1, `bus_wr`=0 and `bus_addr[9:log2(4*GROUPS)]` equal to the same bits of `base_sw` is a decoded read. `rd_oe` is 1 in the cycle after each decoded read and 0 in every other cycle.
- R2: Whenever `rd_oe` is 0, `rd_data` is 00h. A read whose address lies outside the window leaves `rd_oe` at 0.
- R3: A decoded read at window offset 4k+j, with j in {0,1,2}, returns port j of group k. That byte is `lines_in[(3k+j)*8 +: 8]`, and bit n of the byte is line n of the port.
- R4: A decoded read at window offset 4k+3 raises `rd_oe` and returns 00h.
- R5: A write strobe never raises `rd_oe`. After any sequence of writes to the window, reads return the same bytes as before.
- R6: A cycle with both `bus_rd` and `bus_wr` high is not a read: `rd_oe` stays 0.
- R7: The `base_sw` bits below the window alignment have no effect. A base of 30Fh behaves exactly like 300h when the window is 16 bytes.
- R8: A change of an input line that is present before clock edge e is returned by reads captured at edge e+2 and later. Reads captured at e and at e+1 return the earlier value.
- R9: Synchronous active-high reset clears `rd_oe`, `rd_data` and the synchronizer. A read captured at the first edge after reset is released returns 00h for every port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sw | input | ADDR_W | Base-address switch bank, one bit per address line |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, ignored by the block |
| lines_in | input | 24*GROUPS | Asynchronous input lines, port p in bits [8p+7:8p] |
| rd_data | output | 8 | Registered read byte, 00h when not enabled |
| rd_oe | output | 1 | Registered data output enable |

## Verification
The hardest situation to reach from the ports is the exact boundary of the synchronizer latency. A line has to change in the same cycle as a read strobe, and a back-to-back run of reads must then capture the old, old and new values on three consecutive edges. The bench changes the lines right after it issues a read and queues the two stale expectations ahead of the fresh one. A second hard case is the first read after reset. Nonzero lines are held during reset and a read is issued on the very edge that releases it, so the cleared synchronizer state becomes visible.

// File: rtl/ioin_pkg.sv
package ioin_pkg;
  localparam int BYTE_W        = 8;
  localparam int PORTS_PER_GRP = 3;
  localparam int SLOTS_PER_GRP = 4;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t RESERVED_VAL = '0;
endpackage

// File: rtl/ioin_sync.sv
module ioin_sync #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign d_sync = stage2;
endmodule

// File: rtl/ioin_window.sv
module ioin_window #(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 3
) (
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [ADDR_W-OFS_W-1:0]  base_hi,
  output logic                     rd_hit,
  output logic [OFS_W-1:0]         offset
);
  logic match;

  always_comb begin
    match  = (bus_addr[ADDR_W-1:OFS_W] == base_hi);
    rd_hit = bus_rd & ~bus_wr & match;
    offset = bus_addr[OFS_W-1:0];
  end
endmodule

// File: rtl/ioin_portmux.sv
module ioin_portmux
  import ioin_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int OFS_W  = 3
) (
  input  logic [GROUPS*PORTS_PER_GRP*BYTE_W-1:0] lines,
  input  logic [OFS_W-1:0]                       offset,
  output byte_t                                  dout
);
  localparam int GRP_W = OFS_W - 2;

  byte_t grp_byte [GROUPS];
  logic [1:0] slot;

  assign slot = offset[1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    byte_t port_a, port_b, port_c;
    assign port_a = lines[(g*PORTS_PER_GRP+0)*BYTE_W +: BYTE_W];
    assign port_b = lines[(g*PORTS_PER_GRP+1)*BYTE_W +: BYTE_W];
    assign port_c = lines[(g*PORTS_PER_GRP+2)*BYTE_W +: BYTE_W];
    always_comb begin
      unique case (slot)
        2'd0:    grp_byte[g] = port_a;
        2'd1:    grp_byte[g] = port_b;
        2'd2:    grp_byte[g] = port_c;
        default: grp_byte[g] = RESERVED_VAL;
      endcase
    end
  end

  logic [GRP_W-1:0] grp_sel;
  assign grp_sel = offset[OFS_W-1:2];
  assign dout    = grp_byte[grp_sel];
endmodule

// File: rtl/ioin_decoder.sv
module ioin_decoder
  import ioin_pkg::*;
#(
  parameter int GROUPS = 2,   // power of two, at least 2
  parameter int ADDR_W = 10
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [ADDR_W-1:0]                      base_sw,
  input  logic [ADDR_W-1:0]                      bus_addr,
  input  logic                                   bus_rd,
  input  logic                                   bus_wr,
  input  logic [GROUPS*PORTS_PER_GRP*BYTE_W-1:0] lines_in,
  output logic [BYTE_W-1:0]                      rd_data,
  output logic                                   rd_oe
);
  localparam int NLINES = GROUPS * PORTS_PER_GRP * BYTE_W;
  localparam int WIN    = GROUPS * SLOTS_PER_GRP;
  localparam int OFS_W  = $clog2(WIN);

  // switch bits below the window alignment do not take part in the compare
  logic unused_sw_lo;
  assign unused_sw_lo = ^base_sw[OFS_W-1:0];

  logic [NLINES-1:0] lines_s;
  logic              rd_hit;
  logic [OFS_W-1:0]  offset;
  byte_t             mux_byte;

  ioin_sync #(.W(NLINES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (lines_in),
    .d_sync  (lines_s)
  );

  ioin_window #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_win (
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .base_hi  (base_sw[ADDR_W-1:OFS_W]),
    .rd_hit   (rd_hit),
    .offset   (offset)
  );

  ioin_portmux #(.GROUPS(GROUPS), .OFS_W(OFS_W)) u_mux (
    .lines  (lines_s),
    .offset (offset),
    .dout   (mux_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_oe   <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_oe   <= rd_hit;
      rd_data <= rd_hit ? mux_byte : '0;
    end
  end
endmodule

// File: rtl/ioin_checker.sv
module ioin_checker #(
  parameter int GROUPS = 2,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] base_sw,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        rd_data,
  input logic              rd_oe
);
  localparam int OFS_W = $clog2(GROUPS * 4);

  logic in_win;
  assign in_win = (bus_addr[ADDR_W-1:OFS_W] == base_sw[ADDR_W-1:OFS_W]);

  // R1: enable follows a decoded read
  a_r1_hit_gives_oe: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && in_win) |=> rd_oe);

  // R1: enable never without a decoded read one cycle earlier
  a_r1_oe_needs_hit: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> $past(bus_rd && !bus_wr && in_win));

  // R2: data bus quiet while not enabled
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_oe |-> (rd_data == 8'h00));

  // R4: reserved slot reads as zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && in_win && bus_addr[1:0] == 2'b11) |=> (rd_oe && rd_data == 8'h00));

  // R5 and R6: a write strobe never yields a read cycle
  a_r5_write_quiet: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !rd_oe);
endmodule

bind ioin_decoder ioin_checker #(.GROUPS(GROUPS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .base_sw  (base_sw),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .rd_data  (rd_data),
  .rd_oe    (rd_oe)
);

// File: tb/tb_ioin_decoder.sv
module tb_ioin_decoder;
  localparam int G      = 4;
  localparam int AW     = 10;
  localparam int NL     = G * 24;
  localparam int WIN    = G * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] base_sw = 10'h300;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [NL-1:0] lines_in = '0;
  logic [NL-1:0] model = '0;
  logic [7:0]    rd_data;
  logic          rd_oe;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  typedef struct {
    logic       oe;
    logic [7:0] d;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  ioin_decoder #(.GROUPS(G), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .base_sw(base_sw), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .lines_in(lines_in),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  // monitor: compare outputs after each edge with the item queued for it
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rd_oe !== e.oe || rd_data !== e.d) begin
        errors++;
        $display("FAIL %s: got oe=%b data=%02h, expected oe=%b data=%02h",
                 e.tag, rd_oe, rd_data, e.oe, e.d);
      end
    end
  end

  function automatic logic [7:0] exp_byte(input int ofs);
    int slot, grp;
    slot = ofs % 4;
    grp  = ofs / 4;
    if (slot == 3) return 8'h00;
    return model[(grp*3 + slot)*8 +: 8];
  endfunction

  task automatic bus_cyc(input logic rd, input logic wr, input logic [AW-1:0] a,
                         input logic eoe, input logic [7:0] ed, input string tag);
    exp_t e;
    @(negedge clk);
    bus_rd   = rd;
    bus_wr   = wr;
    bus_addr = a;
    e.oe = eoe; e.d = ed; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bus_cyc(1'b0, 1'b0, 10'h000, 1'b0, 8'h00, "R2 idle");
  endtask

  task automatic set_lines(input logic [NL-1:0] v);
    lines_in = v;
    model    = v;
    idle(2);
  endtask

  task automatic sweep(input logic [AW-1:0] base, input string tag);
    for (int o = 0; o < WIN; o++) begin
      if (o % 4 == 3) bus_cyc(1'b1, 1'b0, base + AW'(o), 1'b1, 8'h00, {tag, " R4 reserved"});
      else            bus_cyc(1'b1, 1'b0, base + AW'(o), 1'b1, exp_byte(o), {tag, " R3 port"});
    end
  endtask

  function automatic logic [NL-1:0] pattern(input logic [7:0] seed);
    logic [NL-1:0] v;
    for (int p = 0; p < NL/8; p++) v[p*8 +: 8] = 8'(p * 37) ^ seed;
    return v;
  endfunction

  initial begin
    logic [NL-1:0] p1;
    p1 = pattern(8'hA5);
    lines_in = p1;
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R9 reset state
    if (rd_oe !== 1'b0 || rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R9 reset: got oe=%b data=%02h, expected oe=0 data=00", rd_oe, rd_data);
    end
    // release reset with a read on the same edge: synchronizer still clear
    begin
      exp_t e;
      @(negedge clk);
      rst = 1'b0; bus_rd = 1'b1; bus_addr = 10'h300;
      e.oe = 1'b1; e.d = 8'h00; e.tag = "R9 first read after reset";
      sb.push_back(e);
    end
    model = p1;
    bus_cyc(1'b1, 1'b0, 10'h300, 1'b1, 8'h00, "R9 second edge still old");
    bus_cyc(1'b1, 1'b0, 10'h300, 1'b1, exp_byte(0), "R8 third edge new");
    idle(1);

    // R1/R3/R4 sweep at default base, with misses around it
    sweep(10'h300, "base300");
    bus_cyc(1'b1, 1'b0, 10'h2FF, 1'b0, 8'h00, "R2 below window");
    bus_cyc(1'b1, 1'b0, 10'h310, 1'b0, 8'h00, "R2 above window");

    // base 000h with another pattern
    base_sw = 10'h000;
    set_lines(pattern(8'h3C));
    sweep(10'h000, "base000");
    bus_cyc(1'b1, 1'b0, 10'h010, 1'b0, 8'h00, "R2 above window 000");
    bus_cyc(1'b1, 1'b0, 10'h300, 1'b0, 8'h00, "R2 old base now miss");

    // top of the address space
    base_sw = 10'h3F0;
    set_lines(pattern(8'hF0));
    sweep(10'h3F0, "base3F0");
    bus_cyc(1'b1, 1'b0, 10'h3EF, 1'b0, 8'h00, "R2 below window 3F0");

    // R7: low switch bits ignored
    base_sw = 10'h30F;
    set_lines(pattern(8'h5A));
    sweep(10'h300, "R7 base30F");
    bus_cyc(1'b1, 1'b0, 10'h310, 1'b0, 8'h00, "R7 miss above");

    // R5: writes everywhere, then identical readback
    for (int o = 0; o < WIN; o++) bus_cyc(1'b0, 1'b1, 10'h300 + AW'(o), 1'b0, 8'h00, "R5 write no oe");
    sweep(10'h300, "R5 readback");

    // R6: simultaneous strobes
    bus_cyc(1'b1, 1'b1, 10'h300, 1'b0, 8'h00, "R6 both strobes");
    bus_cyc(1'b1, 1'b1, 10'h305, 1'b0, 8'h00, "R6 both strobes");
    bus_cyc(1'b0, 1'b0, 10'h300, 1'b0, 8'h00, "R1 no strobe");

    // R8: change lines in the cycle of a read
    bus_cyc(1'b1, 1'b0, 10'h301, 1'b1, exp_byte(1), "R8 edge e old");
    begin
      logic [7:0] old1;
      old1 = exp_byte(1);
      lines_in = pattern(8'h0F);
      model    = lines_in;
      bus_cyc(1'b1, 1'b0, 10'h301, 1'b1, old1, "R8 edge e+1 old");
      bus_cyc(1'b1, 1'b0, 10'h301, 1'b1, exp_byte(1), "R8 edge e+2 new");
    end
    // R3 single-bit walk on group 3 port C
    for (int b = 0; b < 8; b++) begin
      logic [NL-1:0] v;
      v = '0;
      v[(3*3+2)*8 + b] = 1'b1;
      set_lines(v);
      bus_cyc(1'b1, 1'b0, 10'h30E, 1'b1, 8'(1 << b), "R3 bit order");
    end
    idle(2);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule